// File: doc/BRIEF.md
# Self-Timed Program Memory Write/Erase Sequencer

This block sits between a processor's register bus and a small on-chip program memory. Software writes one 8-bit control register, presents a word address and a 14-bit data word, and then sets a start bit. The block carries out the command. It can do a one-cycle read of the addressed word, load a single entry of a bank of row write latches, erase a whole row, or program a whole row from the latches. Erase and program are self-timed over a fixed number of cycles. During that interval a busy output is high. At the end, hardware clears the bits it owns.

Two address spaces sit behind the same address input: the main program array and a small configuration/identification array. A control bit chooses between them. An error flag is raised each time software asks for a write or erase. It drops only when that operation ends normally, so software can tell whether a command ran to completion or was refused. The memory is a behavioural register array inside the block. It resets to the erased state (all ones).

Top module: `flash_seq`

## Requirements
- R1: After reset the control register reads 0x80, busy is low, and a read of any main address returns 0x3FFF. Bit 7 of the control register always reads 1.
- R2: Writing the control register with bit 0 = 1 starts a read. In the cycle after the write, bit 0 reads 1. One cycle later it reads 0 and the read data output holds the addressed word of the space chosen by bit 6.
- R3: While busy, or while bit 0 or bit 1 is still set, control-register writes are ignored. In particular, software cannot clear bit 1 or bit 2 during a program.
- R4: With bit 4 = 0 and bit 5 = 1, a write command (bit 1) stores the data word in the latch chosen by the low 2 address bits. The array is left unchanged, busy stays low, and bit 1 and bit 3 read 0 one cycle later.
- R5: With bits 4 and 5 both 0 and bit 2 = 1, a write command loads the addressed latch and then programs the whole 4-word row (address bits 6:2) from the latches. The latches then return to 0x3FFF, so entries that were never loaded program as 0x3FFF.
- R6: With bit 4 = 1 and bit 2 = 1, a write command sets the addressed row to 0x3FFF and clears bit 4 when it finishes. Bit 5 has no effect in this case.
- R7: Bit 3 is set in the same cycle that bit 1 becomes set. It is cleared when a latch load, program or erase completes. Software writes to bit 3 have no effect.
- R8: If bit 1 is set while bit 2 = 0, no operation takes place, the array is unchanged, bit 1 reads 0 one cycle later, and bit 3 stays 1.
- R9: With bit 6 = 1, programs and reads go to a separate 8-word configuration space indexed by the low 3 address bits. The main array is not touched.
- R10: A program or erase holds busy high for exactly OP_CYCLES consecutive cycles (default 16), starting on the cycle after the write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write value |
| ctl_rdata_o | output | 8 | Control register read value |
| addr_i | input | 7 | Word address (row = bits 6:2, latch = bits 1:0) |
| wdata_i | input | 14 | Data word for latch loads |
| rdata_o | output | 14 | Registered read data |
| busy_o | output | 1 | High while a program or erase is in progress |

## Verification
The assertions assume that the address and data inputs hold steady from the control write until the cycle after it, because the latch index, the row number and the read address are sampled one cycle after the command. They also assume that software does not depend on writes that land while a command is pending. The stimulus sets the address and data before each control write and changes them only after the command has been taken up. It issues a control write during a program only as the deliberate test of R3.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int unsigned FS_WORD_W     = 14;
  localparam int unsigned FS_ADDR_W     = 7;
  localparam int unsigned FS_LATCH_W    = 2;
  localparam int unsigned FS_CFG_ADDR_W = 3;
  localparam int unsigned FS_OP_CYCLES  = 16;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_state_e;
endpackage

// File: rtl/flash_latch_bank.sv
module flash_latch_bank #(
  parameter int unsigned WORD_W  = flash_seq_pkg::FS_WORD_W,
  parameter int unsigned LATCH_W = flash_seq_pkg::FS_LATCH_W,
  localparam int unsigned LATCHES = 1 << LATCH_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_i,
  input  logic [LATCH_W-1:0]              idx_i,
  input  logic [WORD_W-1:0]               wdata_i,
  input  logic                            clr_i,
  output logic [LATCHES-1:0][WORD_W-1:0]  row_o
);
  for (genvar i = 0; i < LATCHES; i++) begin : g_lat
    logic [WORD_W-1:0] word_q, word_d;
    always_comb begin
      word_d = word_q;
      if (clr_i) word_d = '1;
      else if (ld_i && idx_i == LATCH_W'(i)) word_d = wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '1;
      else        word_q <= word_d;
    end
    assign row_o[i] = word_q;
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int unsigned WORD_W     = flash_seq_pkg::FS_WORD_W,
  parameter int unsigned ADDR_W     = flash_seq_pkg::FS_ADDR_W,
  parameter int unsigned LATCH_W    = flash_seq_pkg::FS_LATCH_W,
  parameter int unsigned CFG_ADDR_W = flash_seq_pkg::FS_CFG_ADDR_W,
  localparam int unsigned LATCHES   = 1 << LATCH_W,
  localparam int unsigned ROW_W     = ADDR_W - LATCH_W,
  localparam int unsigned MAIN_WORDS = 1 << ADDR_W,
  localparam int unsigned CFG_WORDS  = 1 << CFG_ADDR_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we_i,
  input  logic                            erase_i,
  input  logic                            cfg_i,
  input  logic [ROW_W-1:0]                row_i,
  input  logic [LATCHES-1:0][WORD_W-1:0]  row_data_i,
  input  logic                            re_i,
  input  logic [ADDR_W-1:0]               addr_i,
  output logic [WORD_W-1:0]               rdata_o
);
  logic [WORD_W-1:0] main_rd [MAIN_WORDS];
  logic [WORD_W-1:0] cfg_rd  [CFG_WORDS];
  logic [WORD_W-1:0] rdata_q, rdata_d;

  for (genvar w = 0; w < MAIN_WORDS; w++) begin : g_main
    logic [WORD_W-1:0] cell_q;
    logic              hit;
    assign hit = we_i && !cfg_i && (row_i == ROW_W'(w / LATCHES));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= '1;
      else if (hit) cell_q <= erase_i ? '1 : row_data_i[w % LATCHES];
    end
    assign main_rd[w] = cell_q;
  end

  for (genvar c = 0; c < CFG_WORDS; c++) begin : g_cfg
    logic [WORD_W-1:0] cell_q;
    logic              hit;
    assign hit = we_i && cfg_i &&
                 (row_i[CFG_ADDR_W-LATCH_W-1:0] == (CFG_ADDR_W-LATCH_W)'(c / LATCHES));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= '1;
      else if (hit) cell_q <= erase_i ? '1 : row_data_i[c % LATCHES];
    end
    assign cfg_rd[c] = cell_q;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re_i) rdata_d = cfg_i ? cfg_rd[addr_i[CFG_ADDR_W-1:0]] : main_rd[addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '1;
    else        rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = FS_ADDR_W,
  parameter int unsigned LATCH_W   = FS_LATCH_W,
  parameter int unsigned OP_CYCLES = FS_OP_CYCLES,
  localparam int unsigned ROW_W    = ADDR_W - LATCH_W,
  localparam int unsigned CNT_W    = $clog2(OP_CYCLES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we_i,
  input  logic [7:0]         ctl_wdata_i,
  output logic [7:0]         ctl_rdata_o,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               busy_o,
  output logic               latch_ld_o,
  output logic [LATCH_W-1:0] latch_idx_o,
  output logic               latch_clr_o,
  output logic               arr_we_o,
  output logic               arr_erase_o,
  output logic               arr_re_o,
  output logic               arr_cfg_o,
  output logic [ROW_W-1:0]   arr_row_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OP_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic cfg_q, cfg_d, lwlo_q, lwlo_d, erase_q, erase_d, err_q, err_d;
  logic en_q, en_d, wr_q, wr_d, rd_q, rd_d, op_erase_q, op_erase_d;
  logic accept;
  logic unused_wbits;

  assign unused_wbits = ^{ctl_wdata_i[7], ctl_wdata_i[3]};
  assign accept = ctl_we_i && (state_q == ST_IDLE) && !wr_q && !rd_q;

  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;  row_d = row_q;
    cfg_d = cfg_q;  lwlo_d = lwlo_q;  erase_d = erase_q;  err_d = err_q;
    en_d = en_q;  wr_d = wr_q;  rd_d = rd_q;  op_erase_d = op_erase_q;
    latch_ld_o = 1'b0;  latch_clr_o = 1'b0;  arr_we_o = 1'b0;
    if (accept) begin
      cfg_d   = ctl_wdata_i[6];
      lwlo_d  = ctl_wdata_i[5];
      erase_d = ctl_wdata_i[4];
      en_d    = ctl_wdata_i[2];
      if (ctl_wdata_i[1]) begin
        wr_d  = 1'b1;
        err_d = 1'b1;
      end
      if (ctl_wdata_i[0]) rd_d = 1'b1;
    end
    if (rd_q) rd_d = 1'b0;
    if (state_q == ST_IDLE && wr_q) begin
      if (!en_q) begin
        wr_d = 1'b0;
      end else if (erase_q) begin
        state_d = ST_BUSY;  cnt_d = '0;  op_erase_d = 1'b1;
        row_d = addr_i[ADDR_W-1:LATCH_W];
      end else if (lwlo_q) begin
        latch_ld_o = 1'b1;  wr_d = 1'b0;  err_d = 1'b0;
      end else begin
        latch_ld_o = 1'b1;
        state_d = ST_BUSY;  cnt_d = '0;  op_erase_d = 1'b0;
        row_d = addr_i[ADDR_W-1:LATCH_W];
      end
    end else if (state_q == ST_BUSY) begin
      if (cnt_q == CNT_LAST) begin
        state_d = ST_IDLE;  wr_d = 1'b0;  err_d = 1'b0;  arr_we_o = 1'b1;
        if (op_erase_q) erase_d = 1'b0;
        else            latch_clr_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  cnt_q <= '0;  row_q <= '0;
      cfg_q <= 1'b0;  lwlo_q <= 1'b0;  erase_q <= 1'b0;  err_q <= 1'b0;
      en_q <= 1'b0;  wr_q <= 1'b0;  rd_q <= 1'b0;  op_erase_q <= 1'b0;
    end else begin
      state_q <= state_d;  cnt_q <= cnt_d;  row_q <= row_d;
      cfg_q <= cfg_d;  lwlo_q <= lwlo_d;  erase_q <= erase_d;  err_q <= err_d;
      en_q <= en_d;  wr_q <= wr_d;  rd_q <= rd_d;  op_erase_q <= op_erase_d;
    end
  end

  assign ctl_rdata_o = {1'b1, cfg_q, lwlo_q, erase_q, err_q, en_q, wr_q, rd_q};
  assign busy_o      = (state_q == ST_BUSY);
  assign latch_idx_o = addr_i[LATCH_W-1:0];
  assign arr_erase_o = op_erase_q;
  assign arr_re_o    = rd_q;
  assign arr_cfg_o   = cfg_q;
  assign arr_row_o   = row_q;

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> !rd_q);
  // R3
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ctl_we_i) |=> (wr_q && en_q && $stable({cfg_q, lwlo_q})));
  // R5
  busy_holds_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> wr_q);
  // R7
  err_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_q) |-> err_q);
  // R8
  disabled_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && wr_q && !en_q) |=> (!wr_q && err_q && !busy_o));
  // R6
  erase_clears_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && op_erase_q) |-> !erase_q);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned WORD_W     = FS_WORD_W,
  parameter int unsigned ADDR_W     = FS_ADDR_W,
  parameter int unsigned LATCH_W    = FS_LATCH_W,
  parameter int unsigned CFG_ADDR_W = FS_CFG_ADDR_W,
  parameter int unsigned OP_CYCLES  = FS_OP_CYCLES,
  localparam int unsigned LATCHES   = 1 << LATCH_W,
  localparam int unsigned ROW_W     = ADDR_W - LATCH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic [7:0]        ctl_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              busy_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                           latch_ld, latch_clr, arr_we, arr_erase, arr_re, arr_cfg;
  logic [LATCH_W-1:0]             latch_idx;
  logic [ROW_W-1:0]               arr_row;
  logic [LATCHES-1:0][WORD_W-1:0] latch_row;

  flash_ctrl #(.ADDR_W(ADDR_W), .LATCH_W(LATCH_W), .OP_CYCLES(OP_CYCLES)) i_ctrl (
    .clk, .rst_n(rst_core_n), .ctl_we_i, .ctl_wdata_i, .ctl_rdata_o, .addr_i, .busy_o,
    .latch_ld_o(latch_ld), .latch_idx_o(latch_idx), .latch_clr_o(latch_clr),
    .arr_we_o(arr_we), .arr_erase_o(arr_erase), .arr_re_o(arr_re),
    .arr_cfg_o(arr_cfg), .arr_row_o(arr_row)
  );

  flash_latch_bank #(.WORD_W(WORD_W), .LATCH_W(LATCH_W)) i_latch (
    .clk, .rst_n(rst_core_n), .ld_i(latch_ld), .idx_i(latch_idx), .wdata_i,
    .clr_i(latch_clr), .row_o(latch_row)
  );

  flash_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LATCH_W(LATCH_W),
                .CFG_ADDR_W(CFG_ADDR_W)) i_array (
    .clk, .rst_n(rst_core_n), .we_i(arr_we), .erase_i(arr_erase), .cfg_i(arr_cfg),
    .row_i(arr_row), .row_data_i(latch_row), .re_i(arr_re), .addr_i, .rdata_o
  );
endmodule

// File: tb/test_flash_seq.sv
module test_flash_seq;
  localparam int OPC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic [7:0]  ctl_rdata;
  logic [6:0]  addr = 7'h00;
  logic [13:0] wdata = 14'h0;
  logic [13:0] rdata;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_seq i_flash_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .ctl_rdata_o(ctl_rdata), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy)
  );

  // {cfg, addr[6:0], data[13:0]}
  localparam logic [21:0] VEC [5] = '{
    {1'b0, 7'h05, 14'h1234},
    {1'b0, 7'h40, 14'h2AAA},
    {1'b1, 7'h05, 14'h0155},
    {1'b0, 7'h7F, 14'h0000},
    {1'b1, 7'h02, 14'h3C3C}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic read_word(input logic cfg, input logic [6:0] a, output logic [13:0] d);
    addr = a;
    write_ctl({1'b0, cfg, 6'b000001});
    @(negedge clk);
    d = rdata;
  endtask

  task automatic run_busy(input string req);
    int n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(req, n, OPC);
  endtask

  task automatic program_word(input logic cfg, input logic [6:0] a, input logic [13:0] d);
    addr = a; wdata = d;
    write_ctl({1'b0, cfg, 6'b000110});
    run_busy("R10 program busy length");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [13:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 ctl reset", ctl_rdata, 8'h80);
    check("R1 busy reset", busy, 0);
    read_word(1'b0, 7'h33, d);
    check("R1 erased word", d, 14'h3FFF);

    // R2 read pulse timing
    addr = 7'h00;
    write_ctl(8'h01);
    check("R2 rd set", ctl_rdata, 8'h81);
    @(negedge clk);
    check("R2 rd cleared", ctl_rdata, 8'h80);

    // table: program then read back (R5, R9)
    for (int i = 0; i < 5; i++) begin
      program_word(VEC[i][21], VEC[i][20:14], VEC[i][13:0]);
      check("R7 err cleared after program", ctl_rdata[3], 0);
      read_word(VEC[i][21], VEC[i][20:14], d);
      check("R5/R9 readback", d, VEC[i][13:0]);
    end
    read_word(1'b0, 7'h05, d);
    check("R9 main untouched by cfg program", d, 14'h1234);
    read_word(1'b0, 7'h02, d);
    check("R9 main untouched by cfg at 0x02", d, 14'h3FFF);
    read_word(1'b0, 7'h04, d);
    check("R5 unloaded latch programs ones", d, 14'h3FFF);

    // R4 latch-only loads
    addr = 7'h10; wdata = 14'h0AAA;
    write_ctl(8'h26);
    check("R7 err set with wr", ctl_rdata, 8'hAE);
    @(negedge clk);
    check("R4 latch-only done", ctl_rdata, 8'hA4);
    check("R4 no busy", busy, 0);
    addr = 7'h11; wdata = 14'h0555;
    write_ctl(8'h26);
    @(negedge clk);
    read_word(1'b0, 7'h10, d);
    check("R4 array unchanged", d, 14'h3FFF);
    program_word(1'b0, 7'h12, 14'h0111);
    read_word(1'b0, 7'h10, d);
    check("R5 row latch 0", d, 14'h0AAA);
    read_word(1'b0, 7'h11, d);
    check("R5 row latch 1", d, 14'h0555);
    read_word(1'b0, 7'h12, d);
    check("R5 row latch 2", d, 14'h0111);
    read_word(1'b0, 7'h13, d);
    check("R5 row latch 3", d, 14'h3FFF);

    // R6 erase with latch-only set (ignored)
    addr = 7'h11;
    write_ctl(8'h36);
    run_busy("R10 erase busy length");
    check("R6 erase sel cleared", ctl_rdata, 8'hA4);
    read_word(1'b0, 7'h10, d);
    check("R6 row erased", d, 14'h3FFF);
    read_word(1'b0, 7'h12, d);
    check("R6 row erased 2", d, 14'h3FFF);
    read_word(1'b0, 7'h05, d);
    check("R6 other row kept", d, 14'h1234);

    // R3 write during busy ignored
    addr = 7'h20; wdata = 14'h0777;
    write_ctl(8'h06);
    @(negedge clk);
    check("R10 busy after start", busy, 1);
    ctl_we = 1'b1; ctl_wdata = 8'h40;
    @(negedge clk);
    ctl_we = 1'b0;
    check("R3 ctl unchanged in busy", ctl_rdata, 8'h8E);
    while (busy) @(negedge clk);
    read_word(1'b0, 7'h20, d);
    check("R3 program completed", d, 14'h0777);

    // R8 disabled write refused
    addr = 7'h40; wdata = 14'h0000;
    write_ctl(8'h02);
    check("R7 err set on refused start", ctl_rdata, 8'h8A);
    @(negedge clk);
    check("R8 wr cleared err kept", ctl_rdata, 8'h88);
    check("R8 no busy", busy, 0);
    read_word(1'b0, 7'h40, d);
    check("R8 array unchanged", d, 14'h2AAA);
    check("R7 err not software writable", ctl_rdata, 8'h88);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule